// File: doc/BRIEF.md
# Event channel source selector

This block is one event-routing channel. A select register, written on the peripheral clock, connects the channel to at most one of several event sources. The chosen source is passed to the event users along two paths. The raw path is purely combinational from the source pin, so asynchronous events pass through even when the peripheral clock is stopped. The synchronized path is retimed to the peripheral clock. On that path, level-type and clocked sources appear after two cycles of latency. An asynchronous pulse from a foreign clock, which may be much shorter than a peripheral clock period, is captured in its own clock domain and reappears as exactly one peripheral-clock pulse.

The sources come in four groups, and the parameters set the size of each group. Select codes number the sources from 1 upward: first the synchronous pulse sources, then the synchronous level sources, then the asynchronous pulse sources, then the asynchronous level sources. Code 0 connects nothing. When the selection changes, the synchronized output is held low for a short window, so that moving from one source to another cannot produce a false event.

Top module: `evch_selector`

## Requirements
- R1: A write with `sel_we` high at a rising `pclk` edge loads `sel_wdata` into the select register. With N_SP, N_SL, N_AP and N_AL sources per group, code k in 1..N_SP selects `sp_evt[k-1]`. The next N_SL codes select `sl_evt` in index order, the next N_AP codes select `ap_evt`/`ap_clk`, and the last N_AL codes select `al_evt`. Sources that are not selected have no effect on either output.
- R2: While `rst_n` is low the select register holds 0, and `ev_raw` and `ev_sync` are both 0.
- R3: With select code 0, or any code above N_SP+N_SL+N_AP+N_AL, both outputs stay 0 whatever the sources do.
- R4: `ev_raw` equals the level of the selected source pin with no register in the path. For an asynchronous pulse source, that pin is `ap_evt`. An asynchronous level change reaches `ev_raw` while `pclk` is stopped.
- R5: For a selected synchronous level source or asynchronous level source, `ev_sync` after rising edge n equals the source level sampled at edge n-1.
- R6: Each asynchronous pulse is `ap_evt` high at a rising edge of its `ap_clk`, even if it is shorter than a `pclk` period. Each one produces exactly one `ev_sync` cycle high, starting after the second `pclk` edge that follows the capture.
- R7: A write that changes the select code forces `ev_sync` to 0 for the two cycles after the write edge. A write of the code already held causes no masking.
- R8: A selected synchronous one-cycle pulse appears on `ev_sync` as a one-cycle pulse, two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | SEL_W | Select code to write |
| sp_evt | input | N_SP | Synchronous pulse sources |
| sl_evt | input | N_SL | Synchronous level sources |
| ap_evt | input | N_AP | Asynchronous pulse sources |
| ap_clk | input | N_AP | Clocks of the asynchronous pulse sources |
| al_evt | input | N_AL | Unclocked asynchronous level sources |
| ev_raw | output | 1 | Unretimed channel event |
| ev_sync | output | 1 | Channel event retimed to pclk |

## Verification
The bench fires foreign-clock pulses lasting one nanosecond. A design that sampled the pulse directly would lose these, and one without an edge detector would stretch them into a level. Back-to-back pulses on adjacent cycles check that each pulse is counted separately. The bench switches between two sources that are both high: missing the mask would pass the new level through at once, and a write of an unchanged code checks that the mask is not applied needlessly. Codes above the source count are written while every source is active, to catch a multiplexer that wraps or truncates the code. The clock is stopped to confirm that a pin level still reaches the raw output.

// File: rtl/evch_pkg.sv
package evch_pkg;
   typedef enum logic [1:0] {
      EVK_SYNC_PULSE  = 2'd0,
      EVK_SYNC_LEVEL  = 2'd1,
      EVK_ASYNC_PULSE = 2'd2,
      EVK_ASYNC_LEVEL = 2'd3
   } evk_e;

   function automatic evk_e kind_of(input int idx, input int n_sp,
                                    input int n_sl, input int n_ap);
      if (idx < n_sp)                 return EVK_SYNC_PULSE;
      else if (idx < n_sp + n_sl)     return EVK_SYNC_LEVEL;
      else if (idx < n_sp + n_sl + n_ap) return EVK_ASYNC_PULSE;
      else                            return EVK_ASYNC_LEVEL;
   endfunction
endpackage

// File: rtl/evch_sync2.sv
module evch_sync2 #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("evch_sync2: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/evch_pulse_cap.sv
module evch_pulse_cap #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic src_evt,
   input  logic clk,
   input  logic rst_n,
   output logic pulse
);
   logic tog;
   logic tog_s;
   logic tog_d;

   // source domain: every captured event flips the toggle
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)       tog <= 1'b0;
      else if (src_evt) tog <= ~tog;
   end

   evch_sync2 #(.STAGES(STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (tog),
      .q    (tog_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_d <= 1'b0;
      else        tog_d <= tog_s;
   end

   assign pulse = tog_s ^ tog_d;
endmodule

// File: rtl/evch_selector.sv
module evch_selector
   import evch_pkg::*;
#(
   parameter int N_SP        = 2,
   parameter int N_SL        = 2,
   parameter int N_AP        = 2,
   parameter int N_AL        = 2,
   parameter int SYNC_STAGES = 2,
   parameter int MASK_CYC    = 2,
   localparam int N_SRC      = N_SP + N_SL + N_AP + N_AL,
   localparam int SEL_W      = $clog2(N_SRC + 1)
) (
   input  logic             pclk,
   input  logic             rst_n,
   input  logic             sel_we,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic [N_SP-1:0]  sp_evt,
   input  logic [N_SL-1:0]  sl_evt,
   input  logic [N_AP-1:0]  ap_evt,
   input  logic [N_AP-1:0]  ap_clk,
   input  logic [N_AL-1:0]  al_evt,
   output logic             ev_raw,
   output logic             ev_sync
);
   localparam int MCNT_W = $clog2(MASK_CYC + 1);

   if (N_SP < 1 || N_SL < 1 || N_AP < 1 || N_AL < 1) begin : g_bad_count
      $error("evch_selector: every source group needs at least one input");
   end
   if (MASK_CYC < 1) begin : g_bad_mask
      $error("evch_selector: MASK_CYC must be at least 1");
   end

   logic [N_SRC-1:0]  src_all;
   logic [N_SRC-1:0]  sync_v;
   logic [SEL_W-1:0]  sel_q;
   logic [MCNT_W-1:0] mask_cnt;
   logic              raw_hit;
   logic              sync_hit;

   assign src_all = {al_evt, ap_evt, sl_evt, sp_evt};

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam evk_e KIND = kind_of(i, N_SP, N_SL, N_AP);
      if (KIND == EVK_ASYNC_PULSE) begin : g_cap
         evch_pulse_cap #(.STAGES(SYNC_STAGES)) u_cap (
            .src_clk(ap_clk[i-(N_SP+N_SL)]),
            .src_evt(src_all[i]),
            .clk    (pclk),
            .rst_n  (rst_n),
            .pulse  (sync_v[i])
         );
      end else begin : g_lvl
         evch_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (pclk),
            .rst_n(rst_n),
            .d    (src_all[i]),
            .q    (sync_v[i])
         );
      end
   end

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         mask_cnt <= '0;
      end else if (sel_we && sel_wdata != sel_q) begin
         sel_q    <= sel_wdata;
         mask_cnt <= MCNT_W'(MASK_CYC);
      end else if (mask_cnt != '0) begin
         mask_cnt <= mask_cnt - 1'b1;
      end
   end

   always_comb begin
      raw_hit  = 1'b0;
      sync_hit = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel_q == SEL_W'(i + 1)) begin
            raw_hit  = src_all[i];
            sync_hit = sync_v[i];
         end
      end
   end

   assign ev_raw  = raw_hit;
   assign ev_sync = sync_hit & (mask_cnt == '0);
endmodule

// File: rtl/evch_selector_chk.sv
module evch_selector_chk #(
   parameter int N_SRC = 8,
   parameter int SEL_W = 4
) (
   input logic             pclk,
   input logic             rst_n,
   input logic             sel_we,
   input logic [SEL_W-1:0] sel_wdata,
   input logic [SEL_W-1:0] sel_q,
   input logic             ev_raw,
   input logic             ev_sync
);
   AST_QUIET_IN_RESET: assert property (@(posedge pclk)
      !rst_n |-> (!ev_raw && !ev_sync)); // R2

   AST_LOAD_SEL: assert property (@(posedge pclk) disable iff (!rst_n)
      sel_we |=> (sel_q == $past(sel_wdata))); // R1

   AST_HOLD_SEL: assert property (@(posedge pclk) disable iff (!rst_n)
      !sel_we |=> $stable(sel_q)); // R1

   AST_NO_SOURCE_QUIET: assert property (@(posedge pclk) disable iff (!rst_n)
      (sel_q == '0 || int'(sel_q) > N_SRC) |-> (!ev_raw && !ev_sync)); // R3

   AST_SWITCH_MASK: assert property (@(posedge pclk) disable iff (!rst_n)
      (sel_we && sel_wdata != sel_q) |=> !ev_sync); // R7
endmodule

bind evch_selector evch_selector_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
   .pclk     (pclk),
   .rst_n    (rst_n),
   .sel_we   (sel_we),
   .sel_wdata(sel_wdata),
   .sel_q    (sel_q),
   .ev_raw   (ev_raw),
   .ev_sync  (ev_sync)
);

// File: tb/test_evch_selector.sv
`timescale 1ns/1ps
module test_evch_selector;
   localparam int NSP = 2, NSL = 2, NAP = 2, NAL = 2;
   localparam int N = NSP + NSL + NAP + NAL;
   localparam int SW = $clog2(N + 1);

   logic pclk = 1'b0;
   logic clk_run = 1'b1;
   logic rst_n = 1'b0;
   logic sel_we = 1'b0;
   logic [SW-1:0] sel_wdata = '0;
   logic [NSP-1:0] sp_evt = '0;
   logic [NSL-1:0] sl_evt = '0;
   logic [NAP-1:0] ap_evt = '0;
   logic [NAP-1:0] ap_clk = '0;
   logic [NAL-1:0] al_evt = '0;
   logic [NAP-1:0] ap_par = '0;
   logic ev_raw, ev_sync;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   evch_selector #(.N_SP(NSP), .N_SL(NSL), .N_AP(NAP), .N_AL(NAL)) i_evch_selector (
      .pclk(pclk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
      .sp_evt(sp_evt), .sl_evt(sl_evt), .ap_evt(ap_evt), .ap_clk(ap_clk),
      .al_evt(al_evt), .ev_raw(ev_raw), .ev_sync(ev_sync));

   always begin
      #4;
      if (clk_run) pclk = ~pclk;
   end

   // reference model
   logic [N-1:0] cur, rawv, h1, h2, h3;
   int m_sel, m_cnt;
   assign cur  = {al_evt, ap_par, sl_evt, sp_evt};
   assign rawv = {al_evt, ap_evt, sl_evt, sp_evt};

   function automatic int kind_of(int idx0);
      if (idx0 < NSP) return 0;
      if (idx0 < NSP + NSL) return 1;
      if (idx0 < NSP + NSL + NAP) return 2;
      return 3;
   endfunction

   always @(posedge pclk or negedge rst_n) begin
      if (!rst_n) begin
         h1 <= '0; h2 <= '0; h3 <= '0; m_sel <= 0; m_cnt <= 0;
      end else begin
         h1 <= cur; h2 <= h1; h3 <= h2;
         if (sel_we && int'(sel_wdata) != m_sel) begin
            m_sel <= int'(sel_wdata);
            m_cnt <= 2;
         end else if (m_cnt > 0) begin
            m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic check(input logic act, input logic exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   always @(posedge pclk) begin
      #6;
      begin
         bit valid;
         logic e_raw, e_sync;
         string t_raw, t_sync;
         valid  = (m_sel >= 1 && m_sel <= N);
         e_raw  = 1'b0;
         e_sync = 1'b0;
         t_raw  = "R4 raw path";
         t_sync = "R5 level sync";
         if (!rst_n) begin
            t_raw = "R2 reset raw"; t_sync = "R2 reset sync";
         end else if (!valid) begin
            t_raw = "R3 no source raw"; t_sync = "R3 no source sync";
         end else begin
            e_raw = rawv[m_sel-1];
            case (kind_of(m_sel-1))
               0: begin e_sync = h2[m_sel-1]; t_sync = "R8 sync pulse"; end
               2: begin e_sync = h2[m_sel-1] ^ h3[m_sel-1]; t_sync = "R6 async pulse"; end
               default: e_sync = h2[m_sel-1];
            endcase
            if (m_cnt != 0) begin
               e_sync = 1'b0; t_sync = "R7 switch mask";
            end
         end
         check(ev_raw, e_raw, t_raw);
         check(ev_sync, e_sync, t_sync);
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin
         @(posedge pclk);
         #2;
      end
   endtask

   task automatic write_sel(int code);
      sel_we = 1'b1;
      sel_wdata = SW'(code);
      tick();
      sel_we = 1'b0;
   endtask

   task automatic ap_fire(int j);
      #1 ap_evt[j] = 1'b1;
      #0.5 ap_clk[j] = 1'b1;
      ap_par[j] = ~ap_par[j];
      #0.5 ap_clk[j] = 1'b0;
      ap_evt[j] = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      tick(5);
      check(ev_sync, 1'b0, "R2 reset state");
      rst_n = 1'b1;
      tick(3);

      // sync pulse source, code 1
      write_sel(1);
      tick(3);
      sp_evt[0] = 1'b1; tick(); sp_evt[0] = 1'b0;
      tick(4);
      sp_evt[1] = 1'b1; tick(); sp_evt[1] = 1'b0;   // unselected: R1
      tick(4);

      // sync level source, code 3
      write_sel(3);
      sl_evt[0] = 1'b1; tick(5);
      sl_evt[0] = 1'b0; tick(2);
      sl_evt[0] = 1'b1; tick(3);
      // switch between two high levels, code 4: R7 mask
      sl_evt[1] = 1'b1;
      write_sel(4);
      #4 check(ev_sync, 1'b0, "R7 mask first cycle");
      tick(); #4 check(ev_sync, 1'b0, "R7 mask second cycle");
      tick(); #4 check(ev_sync, 1'b1, "R7 mask released");
      sl_evt = '0;
      tick(3);

      // async pulse source, code 5
      write_sel(5);
      tick(3);
      ap_fire(0); tick(5);
      ap_fire(1); tick(5);                          // unselected: R1
      ap_fire(0); tick();
      ap_fire(0); tick(5);                          // adjacent pulses: R6
      ap_fire(0); tick(2);
      #2 check(ev_sync, 1'b1, "R6 single pulse high");
      tick(); #2 check(ev_sync, 1'b0, "R6 single pulse low");
      tick(3);

      // async level source, code 7, with the clock stopped
      write_sel(7);
      tick(3);
      @(negedge pclk);
      clk_run = 1'b0;
      #20 al_evt[0] = 1'b1;
      #3 check(ev_raw, 1'b1, "R4 raw rise without clock");
      #10 al_evt[0] = 1'b0;
      #3 check(ev_raw, 1'b0, "R4 raw fall without clock");
      #5 clk_run = 1'b1;
      tick(2);
      al_evt[0] = 1'b1; tick(4);
      write_sel(7);                                 // same code: no mask
      #4 check(ev_sync, 1'b1, "R7 same code keeps output");
      tick(2);
      al_evt[0] = 1'b0; tick(3);

      // unused codes with every source active
      for (int c = 0; c < (1 << SW); c++) begin
         if (c == 0 || c > N) begin
            write_sel(c);
            sp_evt = '1; sl_evt = '1; al_evt = '1;
            ap_fire(0);
            tick(3);
            #1 check(ev_raw | ev_sync, 1'b0, "R3 unused code quiet");
            sp_evt = '0; sl_evt = '0; al_evt = '0;
            tick();
         end
      end

      // mixed random traffic
      for (int k = 0; k < 2000; k++) begin
         if ($urandom_range(0, 9) == 0) begin
            sel_we = 1'b1;
            sel_wdata = SW'($urandom_range(0, N + 2));
         end else begin
            sel_we = 1'b0;
         end
         sp_evt = NSP'($urandom);
         sl_evt = ($urandom_range(0, 3) == 0) ? NSL'($urandom) : sl_evt;
         al_evt = ($urandom_range(0, 3) == 0) ? NAL'($urandom) : al_evt;
         if ($urandom_range(0, 2) == 0) ap_fire(int'($urandom_range(0, NAP - 1)));
         tick();
      end
      sel_we = 1'b0;
      tick(4);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule